// File: doc/BRIEF.md
# Two-Wire 16-Bit Register Slave

This block is the target side of a two-wire serial bus. An external controller uses it to read and write a bank of 16-bit registers through an 8-bit register pointer. The block runs on a fast system clock and oversamples the bus clock and data lines. It drives the shared data line in open-drain style through an output-enable: a high enable pulls the line low.

A transfer opens with a start condition and an address byte whose low bit selects the direction. In a write, the next byte sets the pointer, and the data bytes that follow are paired into registers, high byte first. The register file is reached through a plain parallel port with an address, write data, a one-cycle write strobe and combinational read data. In a read, the pointer is first set with a write, then a repeated start with the read-direction address follows, and the block streams register bytes until the controller refuses a byte. The pointer advances once per complete 16-bit register, never per byte, and wraps from 0xFF to 0x00.

Top module: `twi_reg16_slave`

## Requirements
- R1: After reset, and after a stop condition, the block leaves the data line released (`sda_oe` low).
- R2: A start condition is the data line falling while the clock is high, and a stop condition is the data line rising while the clock is high. Every byte is shifted most significant bit first.
- R3: When the first byte after a start carries the parameter `DEV_ADDR` in bits 7..1, the block pulls the data line low for the ninth clock. Bit 0 = 0 selects a write and bit 0 = 1 selects a read.
- R4: When the address bits do not match, the block does not acknowledge and leaves the line released for every later clock, until the next start.
- R5: In a write, the byte after the address loads the 8-bit register pointer, and it is acknowledged.
- R6: Each write data byte is acknowledged. Two bytes, high then low, form one register write, which is issued as a single-cycle `reg_we` with `reg_addr` set to the pointer. A lone trailing byte is never written.
- R7: The pointer increments by one after each complete 16-bit register, in either direction, and wraps from 0xFF to 0x00.
- R8: A repeated start ends a write burst. A following read-direction address makes the block shift out the register at the pointer, high byte first.
- R9: During a read, an acknowledge from the controller (line low on the ninth clock) makes the block send the next byte. A not-acknowledge makes it release the line until the next start.
- R10: The block changes `sda_oe` only while the synchronized clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock from the controller |
| sda_i | input | 1 | Sensed level of the shared data line |
| sda_oe | output | 1 | High pulls the data line low |
| reg_addr | output | 8 | Register pointer presented to the register file |
| reg_wdata | output | 16 | Register write data |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 16 | Register read data for `reg_addr` |

## Verification
The bench sweeps all 128 seven-bit addresses. A design that compared the wrong bits would acknowledge a neighbour or stay silent for its own address. A mismatched transfer is clocked further, to catch a block that wakes up on a later byte. Write and read bursts start at pointer 0xFE, so that a per-byte increment or a missing 8-bit wrap lands data on the wrong register. A lone trailing byte before a stop, and another before a repeated start, must leave the register untouched. Sixteen registers are written and read back in one burst each, and clocking continues past the not-acknowledge to show that a block that kept driving would corrupt the bus.

// File: rtl/twi_reg16_slave.sv
module twi_reg16_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  output logic [7:0]  reg_addr,
  output logic [15:0] reg_wdata,
  output logic        reg_we,
  input  logic [15:0] reg_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_PTR, S_WR, S_RD, S_RACK, S_IGN} st_t;

  st_t        st;
  logic [2:0] scl_p, sda_p;
  logic [3:0] cnt;
  logic       ackph, half, nack;
  logic [7:0] sh, tx, hi, ptr;

  wire scl_s = scl_p[1];
  wire scl_q = scl_p[2];
  wire sda_s = sda_p[1];
  wire sda_q = sda_p[2];

  wire rise  = scl_s & ~scl_q;
  wire fall  = ~scl_s & scl_q;
  wire start = scl_s & scl_q & sda_q & ~sda_s;
  wire stop  = scl_s & scl_q & ~sda_q & sda_s;
  wire match = (sh[7:1] == DEV_ADDR);
  wire [7:0] rd_byte = half ? reg_rdata[7:0] : reg_rdata[15:8];

  assign reg_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      ackph     <= 1'b0;
      half      <= 1'b0;
      nack      <= 1'b0;
      sh        <= '0;
      tx        <= '0;
      hi        <= '0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (start) begin
        st     <= S_DEV;
        cnt    <= '0;
        ackph  <= 1'b0;
        half   <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_DEV, S_PTR, S_WR: begin
            if (rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (fall && cnt == 4'd8 && !ackph) begin
              ackph <= 1'b1;
              case (st)
                S_DEV: begin
                  if (match) sda_oe <= 1'b1;
                  else st <= S_IGN;
                end
                S_PTR: begin
                  sda_oe <= 1'b1;
                  ptr    <= sh;
                  half   <= 1'b0;
                end
                default: begin
                  sda_oe <= 1'b1;
                  half   <= ~half;
                  if (half) begin
                    reg_we    <= 1'b1;
                    reg_wdata <= {hi, sh};
                  end else begin
                    hi <= sh;
                  end
                end
              endcase
            end else if (fall && ackph) begin
              ackph  <= 1'b0;
              cnt    <= '0;
              sda_oe <= 1'b0;
              case (st)
                S_DEV: begin
                  if (sh[0]) begin
                    st     <= S_RD;
                    tx     <= rd_byte;
                    sda_oe <= ~rd_byte[7];
                  end else begin
                    st <= S_PTR;
                  end
                end
                S_PTR:   st <= S_WR;
                default: if (!half) ptr <= ptr + 8'd1;
              endcase
            end
          end
          S_RD: begin
            if (rise) begin
              cnt <= cnt + 4'd1;
            end else if (fall) begin
              if (cnt < 4'd8) begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end else begin
                sda_oe <= 1'b0;
                st     <= S_RACK;
                half   <= ~half;
                if (half) ptr <= ptr + 8'd1;
              end
            end
          end
          S_RACK: begin
            if (rise) begin
              nack <= sda_s;
            end else if (fall) begin
              if (nack) begin
                st <= S_IGN;
              end else begin
                st     <= S_RD;
                cnt    <= '0;
                tx     <= rd_byte;
                sda_oe <= ~rd_byte[7];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  // R4
  ign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGN) |-> !sda_oe);

  // R6
  we_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> sda_oe);

  // R6
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R7
  ptr_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_addr) |-> !$past(scl_s));

endmodule

// File: tb/tb_twi_reg16_slave.sv
`timescale 1ns/1ps
module tb_twi_reg16_slave;
  localparam logic [6:0] DEV = 7'h48;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, init_req = 1'b0;
  logic sda_oe, reg_we, sda_line;
  logic [7:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [15:0] mem   [256];
  logic [15:0] model [256];
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;
  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (init_req) begin
      for (int i = 0; i < 256; i++) mem[i] <= 16'(i * 16'h0101) ^ 16'h5A00;
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
  end

  twi_reg16_slave #(.DEV_ADDR(DEV)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c();
    sda_m = 1'b0; tick(20); scl = 1'b0; tick(10);
  endtask

  task automatic rstart_c();
    sda_m = 1'b1; tick(10); scl = 1'b1; tick(10); sda_m = 1'b0; tick(10); scl = 1'b0; tick(10);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; tick(10); scl = 1'b1; tick(10); sda_m = 1'b1; tick(20);
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; tick(10); scl = 1'b1; tick(20); scl = 1'b0; tick(10);
  endtask

  task automatic recv_bit(output bit b);
    sda_m = 1'b1; tick(10); scl = 1'b1; tick(10); b = sda_line; tick(10); scl = 1'b0; tick(10);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(ack);
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit ackbit);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(ackbit);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    bit ack;
    logic [7:0] rb;
    logic [7:0] p;
    logic [15:0] w;

    init_req = 1'b1;
    tick(4);
    init_req = 1'b0;
    for (int i = 0; i < 256; i++) model[i] = 16'(i * 16'h0101) ^ 16'h5A00;
    rst_n = 1'b1;
    tick(5);
    // R1: released after reset
    chk(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);

    // R3 R4 R2: address sweep, write direction
    for (int a = 0; a < 128; a++) begin
      start_c();
      send_byte({a[6:0], 1'b0}, ack);
      if (a == DEV) chk(ack == 1'b0, "R3 address ack", ack, 0);
      else          chk(ack == 1'b1, "R4 address nack", ack, 1);
      stop_c();
      // R1: released after stop
      chk(sda_oe == 1'b0, "R1 released after stop", sda_oe, 0);
    end

    // R4: mismatch followed by more clocks stays silent
    start_c();
    send_byte({DEV ^ 7'h01, 1'b0}, ack);
    chk(ack == 1'b1, "R4 near-miss nack", ack, 1);
    send_byte(8'h00, ack);
    chk(ack == 1'b1, "R4 later byte nack", ack, 1);
    recv_byte(rb, 1'b1);
    chk(rb == 8'hFF, "R4 line untouched", rb, 8'hFF);
    stop_c();

    // R5 R6 R7: write burst across pointer wrap
    start_c();
    send_byte({DEV, 1'b0}, ack);
    chk(ack == 1'b0, "R3 write address ack", ack, 0);
    send_byte(8'hFE, ack);
    chk(ack == 1'b0, "R5 pointer ack", ack, 0);
    for (int k = 0; k < 3; k++) begin
      w = 16'hC3A5 ^ 16'(k * 16'h1357);
      send_byte(w[15:8], ack);
      chk(ack == 1'b0, "R6 high byte ack", ack, 0);
      send_byte(w[7:0], ack);
      chk(ack == 1'b0, "R6 low byte ack", ack, 0);
      p = 8'hFE + 8'(k);
      model[p] = w;
    end
    stop_c();
    for (int k = -1; k < 4; k++) begin
      p = 8'hFE + 8'(k);
      chk(mem[p] == model[p], "R7 burst wrap contents", mem[p], model[p]);
    end

    // R6: lone trailing byte before stop is not written
    start_c();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h20, ack);
    send_byte(8'h77, ack);
    chk(ack == 1'b0, "R6 lone byte ack", ack, 0);
    stop_c();
    chk(mem[8'h20] == model[8'h20], "R6 lone byte not written", mem[8'h20], model[8'h20]);

    // R8 R7 R9: read burst across wrap
    start_c();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'hFE, ack);
    rstart_c();
    send_byte({DEV, 1'b1}, ack);
    chk(ack == 1'b0, "R3 read address ack", ack, 0);
    for (int k = 0; k < 6; k++) begin
      recv_byte(rb, k == 5);
      p = 8'hFE + 8'(k / 2);
      w = model[p];
      chk(rb == ((k % 2 == 0) ? w[15:8] : w[7:0]), "R8 R7 read byte", rb,
          (k % 2 == 0) ? w[15:8] : w[7:0]);
    end
    recv_byte(rb, 1'b1);
    chk(rb == 8'hFF, "R9 released after nack", rb, 8'hFF);
    stop_c();

    // R8 R6: repeated start ends a write burst with a trailing byte
    start_c();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h40, ack);
    send_byte(8'h12, ack);
    send_byte(8'h34, ack);
    model[8'h40] = 16'h1234;
    send_byte(8'hAB, ack);
    rstart_c();
    send_byte({DEV, 1'b1}, ack);
    recv_byte(rb, 1'b0);
    chk(rb == model[8'h41][15:8], "R8 read after write burst hi", rb, model[8'h41][15:8]);
    recv_byte(rb, 1'b1);
    chk(rb == model[8'h41][7:0], "R8 read after write burst lo", rb, model[8'h41][7:0]);
    stop_c();
    chk(mem[8'h40] == 16'h1234, "R6 committed register", mem[8'h40], 16'h1234);

    // R6 R7 R8 R9: sixteen-register write sweep and read back
    start_c();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h80, ack);
    for (int k = 0; k < 16; k++) begin
      w = 16'(k * 16'h0F1D) ^ 16'h8001;
      send_byte(w[15:8], ack);
      send_byte(w[7:0], ack);
      model[8'h80 + 8'(k)] = w;
    end
    rstart_c();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h80, ack);
    rstart_c();
    send_byte({DEV, 1'b1}, ack);
    for (int k = 0; k < 32; k++) begin
      recv_byte(rb, k == 31);
      w = model[8'h80 + 8'(k / 2)];
      chk(rb == ((k % 2 == 0) ? w[15:8] : w[7:0]), "R8 sweep read", rb,
          (k % 2 == 0) ? w[15:8] : w[7:0]);
    end
    stop_c();
    chk(mem[8'h90] == model[8'h90], "R7 no spill past burst", mem[8'h90], model[8'h90]);
    chk(sda_oe == 1'b0, "R9 idle after read", sda_oe, 0);

    summary();
  end
endmodule